// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This block resolves control transfers for a single-issue pipelined core whose instruction set has one architectural delay slot. Each cycle the execute stage may present one instruction. When that instruction is a branch or jump, the block evaluates its condition from the source operands and, one clock later, issues a one-cycle redirect to fetch carrying the new program counter. By then the instruction in the delay slot has already been fetched, so it runs no matter how the branch resolves.

Two kinds of branch get special handling. The "likely" sign-test branches cancel their delay-slot instruction when they are not taken, and the block pulses an annul strobe to do this. The jump-and-link form writes the return address into the link register. That address skips both the jump and its delay slot. A branch that arrives while a delay slot is still open is an illegal sequence. The block flags it and drops every effect it would have had.

The byte-lane test compares the two operands one lane at a time. It needs only one equal lane to take the branch. The lane width and the data width are parameters.

Top module: `branch_resolve_unit`

## Requirements
- R1: Only cycles with `issue_i` high are considered. With `issue_i` low, `kind_i` is ignored: no pulse appears, `next_pc_o` holds, and no delay slot is opened. Kind encoding: 0 none, 1 sign-positive, 2 sign-nonpositive, 3 sign-positive likely, 4 sign-nonpositive likely, 5 lane match, 6 jump, 7 jump-and-link.
- R2: Kinds 1 and 3 are taken exactly when `rs_i`, read as a signed value, is greater than zero.
- R3: Kinds 2 and 4 are taken exactly when `rs_i`, read as a signed value, is zero or negative.
- R4: Kind 5 is taken when at least one `LANE_W`-bit lane of `rs_i` equals the lane at the same position in `rt_i`.
- R5: Kinds 6 and 7 are always taken.
- R6: A legal branch that is taken pulses `redirect_o` in the cycle after its issue and sets `next_pc_o` to `target_i`. A legal branch that is not taken sets `next_pc_o` to `pc_i + 8` and does not pulse `redirect_o`.
- R7: `annul_o` pulses in the cycle after issue only for a likely kind (3 or 4) that is not taken. It never pulses for any other kind.
- R8: Kind 7 pulses `link_we_o` in the cycle after issue, with `link_idx_o` = 31 and `link_data_o` = `pc_i + 8`.
- R9: The delay slot is the next issued instruction after a legal branch. A branch issued in that slot pulses `illegal_o` and causes no redirect, annul or link write, and `next_pc_o` keeps its value. That instruction still uses up the slot.
- R10: While reset is asserted and afterwards until the first branch, every pulse output and `next_pc_o` read zero.
- R11: Every pulse output lasts exactly one cycle for each issue that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction is in execute this cycle |
| kind_i | input | 3 | Decoded branch kind (R1 encoding) |
| rs_i | input | XLEN | First source operand |
| rt_i | input | XLEN | Second source operand (lane test) |
| pc_i | input | XLEN | Address of the issued instruction |
| target_i | input | XLEN | Precomputed branch target |
| redirect_o | output | 1 | Fetch redirect pulse |
| next_pc_o | output | XLEN | Resolved next address |
| annul_o | output | 1 | Cancel the delay-slot instruction |
| link_we_o | output | 1 | Link register write pulse |
| link_idx_o | output | REG_W | Link register index |
| link_data_o | output | XLEN | Return address |
| illegal_o | output | 1 | Branch issued in a delay slot |

## Verification
The bench builds the unit with an 8-bit data path and 2-bit lanes. With that width, all 256 operand values run through each sign-test kind, so both sides of the zero and sign boundaries are covered, along with the most negative value. For the lane test, `rt_i` is formed as `rs_i` XOR a mask, and all 256 masks are applied to many `rs_i` values. This produces every combination of matching and differing lanes across the four lanes. Directed sequences check address wrap on `pc_i + 8`, a branch placed in a delay slot, and kinds presented without `issue_i`.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_GTZ  = 3'd1,
    BR_LEZ  = 3'd2,
    BR_GTZL = 3'd3,
    BR_LEZL = 3'd4,
    BR_LANE = 3'd5,
    BR_JMP  = 3'd6,
    BR_JAL  = 3'd7
  } br_kind_e;

  typedef struct packed {
    logic is_branch;
    logic taken;
    logic likely;
    logic link;
  } br_eval_t;
endpackage

// File: rtl/brc_lane_cmp.sv
module brc_lane_cmp #(
  parameter int XLEN   = 32,
  parameter int LANE_W = 8
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic            hit_o
);
  localparam int NLANES = XLEN / LANE_W;

  logic [NLANES-1:0] lane_eq;

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    assign lane_eq[g] = (a_i[g*LANE_W +: LANE_W] == b_i[g*LANE_W +: LANE_W]);
  end

  assign hit_o = |lane_eq;

  always_comb begin
    AST_LANE_ALL_EQ: assert (!(a_i == b_i) || hit_o); // R4
  end
endmodule

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
  import brc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_kind_e        kind_i,
  input  logic [XLEN-1:0] rs_i,
  input  logic            lane_hit_i,
  output br_eval_t        eval_o
);
  logic rs_pos;

  // signed rs > 0: sign clear and nonzero
  assign rs_pos = !rs_i[XLEN-1] && (|rs_i);

  always_comb begin
    eval_o = '0;
    unique case (kind_i)
      BR_NONE: eval_o = '0;
      BR_GTZ:  begin eval_o.is_branch = 1'b1; eval_o.taken = rs_pos; end
      BR_LEZ:  begin eval_o.is_branch = 1'b1; eval_o.taken = !rs_pos; end
      BR_GTZL: begin eval_o.is_branch = 1'b1; eval_o.taken = rs_pos;  eval_o.likely = 1'b1; end
      BR_LEZL: begin eval_o.is_branch = 1'b1; eval_o.taken = !rs_pos; eval_o.likely = 1'b1; end
      BR_LANE: begin eval_o.is_branch = 1'b1; eval_o.taken = lane_hit_i; end
      BR_JMP:  begin eval_o.is_branch = 1'b1; eval_o.taken = 1'b1; end
      BR_JAL:  begin eval_o.is_branch = 1'b1; eval_o.taken = 1'b1; eval_o.link = 1'b1; end
      default: eval_o = '0;
    endcase
  end

  always_comb begin
    AST_UNCOND_TAKEN: assert (!(kind_i == BR_JMP || kind_i == BR_JAL) || eval_o.taken); // R5
  end
endmodule

// File: rtl/brc_slot_track.sv
module brc_slot_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic is_branch_i,
  output logic legal_o,
  output logic illegal_o
);
  logic in_slot_q;

  assign legal_o   = issue_i && is_branch_i && !in_slot_q;
  assign illegal_o = issue_i && is_branch_i &&  in_slot_q;

  // any issue consumes the open slot; only a legal branch opens one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      in_slot_q <= 1'b0;
    else if (issue_i) in_slot_q <= legal_o;
  end

  AST_SLOT_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_slot_q && issue_i) |=> !in_slot_q); // R9
  AST_IDLE_HOLDS_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(in_slot_q)); // R1
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int LANE_W     = 8,
  parameter int INSN_BYTES = 4,
  parameter int REG_W      = 5,
  parameter int LINK_REG   = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [2:0]       kind_i,
  input  logic [XLEN-1:0]  rs_i,
  input  logic [XLEN-1:0]  rt_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  target_i,
  output logic             redirect_o,
  output logic [XLEN-1:0]  next_pc_o,
  output logic             annul_o,
  output logic             link_we_o,
  output logic [REG_W-1:0] link_idx_o,
  output logic [XLEN-1:0]  link_data_o,
  output logic             illegal_o
);
  localparam logic [XLEN-1:0]  SLOT_SKIP = XLEN'(2 * INSN_BYTES);
  localparam logic [REG_W-1:0] LINK_IDX  = REG_W'(LINK_REG);

  br_kind_e        kind;
  logic            lane_hit;
  br_eval_t        eval;
  logic            legal, illegal;
  logic [XLEN-1:0] fall_pc;

  assign kind    = br_kind_e'(kind_i);
  assign fall_pc = pc_i + SLOT_SKIP;

  brc_lane_cmp #(.XLEN(XLEN), .LANE_W(LANE_W)) lane_i (
    .a_i   (rs_i),
    .b_i   (rt_i),
    .hit_o (lane_hit)
  );

  brc_cond_eval #(.XLEN(XLEN)) eval_i (
    .kind_i     (kind),
    .rs_i       (rs_i),
    .lane_hit_i (lane_hit),
    .eval_o     (eval)
  );

  brc_slot_track slot_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .is_branch_i (eval.is_branch),
    .legal_o     (legal),
    .illegal_o   (illegal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o  <= 1'b0;
      annul_o     <= 1'b0;
      link_we_o   <= 1'b0;
      illegal_o   <= 1'b0;
      next_pc_o   <= '0;
      link_data_o <= '0;
    end else begin
      redirect_o <= legal && eval.taken;
      annul_o    <= legal && eval.likely && !eval.taken;
      link_we_o  <= legal && eval.link;
      illegal_o  <= illegal;
      if (legal) next_pc_o <= eval.taken ? target_i : fall_pc;
      if (legal && eval.link) link_data_o <= fall_pc;
    end
  end

  assign link_idx_o = LINK_IDX;

  AST_ANNUL_ONLY_LIKELY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> $past(issue_i && (kind_i == BR_GTZL || kind_i == BR_LEZL))); // R7
  AST_REDIRECT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o); // R11
  AST_ILLEGAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !redirect_o && !annul_o && !link_we_o && $stable(next_pc_o)); // R9
  AST_LINK_REDIRECTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_we_o |-> redirect_o && $past(kind_i == BR_JAL)); // R8
  AST_ISSUE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> !redirect_o && !annul_o && !link_we_o && !illegal_o); // R1
  AST_ANNUL_NOT_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    annul_o |-> !redirect_o); // R7
endmodule

// File: tb/branch_resolve_unit_tb_top.sv
module branch_resolve_unit_tb_top;
  import brc_pkg::*;

  localparam int XW = 8;
  localparam int LW = 2;
  localparam int NL = XW / LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue = 1'b0;
  logic [2:0]    kind = 3'd0;
  logic [XW-1:0] rs = '0, rt = '0, pc = '0, tgt = '0;
  logic          redirect, annul, link_we, illegal;
  logic [XW-1:0] next_pc, link_data;
  logic [4:0]    link_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  branch_resolve_unit #(.XLEN(XW), .LANE_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .kind_i(kind),
    .rs_i(rs), .rt_i(rt), .pc_i(pc), .target_i(tgt),
    .redirect_o(redirect), .next_pc_o(next_pc), .annul_o(annul),
    .link_we_o(link_we), .link_idx_o(link_idx), .link_data_o(link_data),
    .illegal_o(illegal)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_taken(input logic [2:0] k, input logic [XW-1:0] a, input logic [XW-1:0] b);
    bit hit = 1'b0;
    for (int l = 0; l < NL; l++)
      if (((a >> (l*LW)) & ((1 << LW) - 1)) == ((b >> (l*LW)) & ((1 << LW) - 1))) hit = 1'b1;
    case (k)
      3'd1, 3'd3: return $signed(a) > 0;
      3'd2, 3'd4: return $signed(a) <= 0;
      3'd5:       return hit;
      3'd6, 3'd7: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

  // branch then a plain delay-slot instruction
  task automatic run_branch(input logic [2:0] k, input logic [XW-1:0] a, input logic [XW-1:0] b,
                            input logic [XW-1:0] p, input logic [XW-1:0] t, input string req);
    bit tk;
    bit lk;
    logic [XW-1:0] fall;
    tk   = exp_taken(k, a, b);
    lk   = (k == 3'd3 || k == 3'd4);
    fall = p + 8'd8;
    @(negedge clk);
    issue = 1'b1; kind = k; rs = a; rt = b; pc = p; tgt = t;
    @(posedge clk); #1;
    chk(req, "redirect", redirect, tk);
    chk(tk ? "R6" : req, "next_pc", next_pc, tk ? t : fall);
    chk("R7", "annul", annul, lk && !tk);
    chk("R8", "link_we", link_we, k == 3'd7);
    if (k == 3'd7) begin
      chk("R8", "link_data", link_data, fall);
      chk("R8", "link_idx", link_idx, 31);
    end
    chk("R9", "illegal", illegal, 0);
    @(negedge clk);
    kind = 3'd0;
    @(posedge clk); #1;
    chk("R11", "redirect end", redirect, 0);
    chk("R11", "annul end", annul, 0);
    chk("R11", "link end", link_we, 0);
    @(negedge clk);
    issue = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "redirect in reset", redirect, 0);
    chk("R10", "next_pc in reset", next_pc, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R10", "redirect", redirect, 0);
    chk("R10", "annul", annul, 0);
    chk("R10", "link_we", link_we, 0);
    chk("R10", "illegal", illegal, 0);
    chk("R10", "next_pc", next_pc, 0);

    // sign tests, all operand values
    for (int k = 1; k <= 4; k++)
      for (int v = 0; v < 256; v++)
        run_branch(3'(k), 8'(v), 8'(~v), 8'(v * 4), 8'(v + 3), (k == 1 || k == 3) ? "R2" : "R3");

    // lane test: every lane match pattern
    for (int v = 0; v < 256; v += 3)
      for (int m = 0; m < 256; m++)
        run_branch(3'd5, 8'(v), 8'(v ^ m), 8'(m), 8'(v), "R4");

    // unconditional, including pc+8 wrap
    run_branch(3'd6, 8'h80, 8'h00, 8'h10, 8'h44, "R5");
    run_branch(3'd7, 8'h00, 8'h00, 8'hFC, 8'h20, "R5");
    run_branch(3'd7, 8'h01, 8'h00, 8'h30, 8'h90, "R8");

    // issue low: kind ignored, no slot opened
    @(negedge clk);
    issue = 1'b0; kind = 3'd6; tgt = 8'hEE;
    @(posedge clk); #1;
    chk("R1", "redirect idle", redirect, 0);
    @(posedge clk); #1;
    chk("R1", "next_pc idle", next_pc, 8'h90);
    chk("R1", "illegal idle", illegal, 0);
    run_branch(3'd1, 8'h05, 8'h00, 8'h40, 8'h66, "R1");

    // branch in delay slot
    @(negedge clk);
    issue = 1'b1; kind = 3'd6; pc = 8'h50; tgt = 8'hA0;
    @(posedge clk); #1;
    chk("R6", "first redirect", redirect, 1);
    @(negedge clk);
    kind = 3'd7; pc = 8'h54; tgt = 8'hC0;
    @(posedge clk); #1;
    chk("R9", "illegal", illegal, 1);
    chk("R9", "redirect suppressed", redirect, 0);
    chk("R9", "link suppressed", link_we, 0);
    chk("R9", "next_pc held", next_pc, 8'hA0);
    @(negedge clk);
    kind = 3'd4; rs = 8'h01; pc = 8'h58;
    @(posedge clk); #1;
    chk("R9", "slot consumed", illegal, 0);
    chk("R7", "likely not taken annul", annul, 1);
    chk("R6", "next_pc fall", next_pc, 8'h60);
    @(negedge clk);
    kind = 3'd0;
    @(posedge clk); #1;
    chk("R11", "annul end", annul, 0);
    chk("R11", "illegal end", illegal, 0);
    @(negedge clk);
    issue = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule